// File: doc/BRIEF.md
# I2C Event Status Flag Controller

This block holds the event flags that a serial-bus protocol engine reports to the CPU, and it decides when each flag may drop. The engine sends one-cycle pulses when a start condition has gone out, when the block has been addressed as a target, when a byte has finished, when a 10-bit header has gone out, when a controller-side address has been acknowledged, when an acknowledge fails, and when a stop condition is seen. Each pulse sets a flag. A summary event bit is the OR of all flags. It drives an interrupt output when the interrupt-enable bit of the control register is set.

The CPU has one-cycle access strobes: reads of two status registers, a read and a write of the data register, and a write of the control register. Most flags clear only through a two-step sequence. First comes a status-1 read, taken while some flag is pending, which arms the block. The next access then completes the clear, but only if it is the access that flag calls for. Any other access drops the arm. A failed acknowledge gets special handling: the pending byte flag can also be released by a data write alone, or by setting and then clearing the stop bit of the control register. The second method also hides the next stop event. The bus issues at most one access per cycle.

Top module: `i2c_evt_flags`

## Requirements
- R1: After reset, sr1_o, sr2_o, cr_o and irq_o are all zero.
- R2: The summary bit evf_o, also shown at sr1_o bit 7, is 1 exactly when any flag is set. irq_o equals evf_o AND control bit 0, the interrupt enable. A control write loads cr_o from wdata_i. cr_o holds its value between writes.
- R3: The target-addressed flag (sr1_o bit 1) clears on any status-1 read.
- R4: With tx_mode_i = 0, the byte-done flag (sr1_o bit 2) clears only when an armed data read follows a status-1 read. A data read alone leaves it set.
- R5: With tx_mode_i = 1, the byte-done flag clears only when an armed data write follows a status-1 read. A data read in the second step leaves it set.
- R6: The start-sent flag (sr1_o bit 0) and the header-sent flag (sr1_o bit 3) clear when an armed data write follows a status-1 read.
- R7: The controller-address-acknowledged flag (sr1_o bit 4) clears only when an armed control write follows a status-1 read. An armed data write leaves it set.
- R8: The stop-seen flag (sr2_o bit 1) clears on a status-2 read. A status-1 read leaves it set.
- R9: The ack-failure flag (sr2_o bit 0) clears on a status-1 read. A byte-done flag set together with a failed acknowledge clears on an unarmed data write. It also clears when a control write changes control bit 1 (the stop bit) from 1 to 0.
- R10: After a byte-done flag has been released through the stop-bit toggle, the next stop pulse does not set the stop-seen flag. A later stop pulse does set it.
- R11: A status-1 read arms only if some flag is pending. Any other access after the arm disarms it, so the later completing access clears nothing.
- R12: An event pulse in the same cycle as a clear of its own flag leaves the flag set.
- R13: Under mixed random events and accesses, sr1_o, sr2_o and irq_o follow the rules above on every cycle, with each change visible one clock after the pulse or access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_mode_i | input | 1 | 1 = transmit, 0 = receive; selects the byte-done clear access |
| evt_start_i | input | 1 | Start condition sent |
| evt_slv_hit_i | input | 1 | Block addressed as target |
| evt_byte_done_i | input | 1 | Byte transfer finished |
| evt_hdr_sent_i | input | 1 | 10-bit header sent |
| evt_mst_ack_i | input | 1 | Controller-side address acknowledged |
| evt_nack_i | input | 1 | Acknowledge failure |
| evt_stop_i | input | 1 | Stop condition seen |
| rd_sr1_i | input | 1 | Status-1 read strobe |
| rd_sr2_i | input | 1 | Status-2 read strobe |
| rd_dr_i | input | 1 | Data read strobe |
| wr_dr_i | input | 1 | Data write strobe |
| wr_cr_i | input | 1 | Control write strobe |
| wdata_i | input | DATA_W | Control write data |
| sr1_o | output | DATA_W | Status 1: bits 0..4 flags, bit 7 summary |
| sr2_o | output | DATA_W | Status 2: bit 0 ack failure, bit 1 stop seen |
| cr_o | output | DATA_W | Control register |
| evf_o | output | 1 | Summary event bit |
| irq_o | output | 1 | Interrupt request |

## Verification
An engine pulse and a CPU access that clears the same flag can land on the same clock edge. Directed steps drive a start pulse together with the completing armed data write, and a target-hit pulse together with a status-1 read. Both flags are expected to remain set. Random traffic also produces many such collisions, along with stop pulses that meet the mute window. Each is judged against a bench model in which the set always wins.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int NFLAG     = 7;
  localparam int F_START   = 0;
  localparam int F_SLV     = 1;
  localparam int F_BYTE    = 2;
  localparam int F_HDR     = 3;
  localparam int F_MACK    = 4;
  localparam int F_NACK    = 5;
  localparam int F_STOP    = 6;
  localparam int NFLAG_SR1 = 5;
  localparam int CR_IE     = 0;
  localparam int CR_STOP   = 1;
endpackage

// File: rtl/evt_flag_cell.sv
module evt_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o); // R12
  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o); // R11
endmodule

// File: rtl/evt_arm_track.sv
module evt_arm_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_i,
  input  logic rd_sr1_i,
  input  logic other_acc_i,
  output logic armed_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          armed_o <= 1'b0;
    else if (rd_sr1_i)    armed_o <= pend_i;
    else if (other_acc_i) armed_o <= 1'b0;
  end

  AST_ARM_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (other_acc_i && !rd_sr1_i) |=> !armed_o); // R11
  AST_ARM_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sr1_i && !pend_i) |=> !armed_o); // R11
endmodule

// File: rtl/evt_ctrl_reg.sv
module evt_ctrl_reg import i2c_evt_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] cr_o,
  output logic              stop_fall_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cr_o <= '0;
    else if (wr_i) cr_o <= wdata_i;
  end

  // stop bit 1 -> 0 releases the lines
  assign stop_fall_o = wr_i & cr_o[CR_STOP] & ~wdata_i[CR_STOP];

  AST_CR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(cr_o)); // R2
  AST_CR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (cr_o == $past(wdata_i))); // R2
endmodule

// File: rtl/i2c_evt_flags.sv
module i2c_evt_flags import i2c_evt_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_mode_i,
  input  logic              evt_start_i,
  input  logic              evt_slv_hit_i,
  input  logic              evt_byte_done_i,
  input  logic              evt_hdr_sent_i,
  input  logic              evt_mst_ack_i,
  input  logic              evt_nack_i,
  input  logic              evt_stop_i,
  input  logic              rd_sr1_i,
  input  logic              rd_sr2_i,
  input  logic              rd_dr_i,
  input  logic              wr_dr_i,
  input  logic              wr_cr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] sr1_o,
  output logic [DATA_W-1:0] sr2_o,
  output logic [DATA_W-1:0] cr_o,
  output logic              evf_o,
  output logic              irq_o
);
  localparam int EVF_BIT = DATA_W - 1;

  logic [NFLAG-1:0] set_v, clr_v, flag_q;
  logic armed, other_acc, stop_fall, nack_rel, byte_next;
  logic nack_q, mute_q;

  assign other_acc = rd_sr2_i | rd_dr_i | wr_dr_i | wr_cr_i;
  assign nack_rel  = nack_q & (wr_dr_i | stop_fall);

  always_comb begin
    set_v[F_START] = evt_start_i;
    set_v[F_SLV]   = evt_slv_hit_i;
    set_v[F_BYTE]  = evt_byte_done_i;
    set_v[F_HDR]   = evt_hdr_sent_i;
    set_v[F_MACK]  = evt_mst_ack_i;
    set_v[F_NACK]  = evt_nack_i;
    set_v[F_STOP]  = evt_stop_i & ~mute_q;

    clr_v[F_START] = armed & wr_dr_i;
    clr_v[F_SLV]   = rd_sr1_i;
    clr_v[F_BYTE]  = (armed & (tx_mode_i ? wr_dr_i : rd_dr_i)) | nack_rel;
    clr_v[F_HDR]   = armed & wr_dr_i;
    clr_v[F_MACK]  = armed & wr_cr_i;
    clr_v[F_NACK]  = rd_sr1_i;
    clr_v[F_STOP]  = rd_sr2_i;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    evt_flag_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_v[g]),
      .clr_i  (clr_v[g]),
      .q_o    (flag_q[g])
    );
  end

  evt_arm_track u_arm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pend_i      (evf_o),
    .rd_sr1_i    (rd_sr1_i),
    .other_acc_i (other_acc),
    .armed_o     (armed)
  );

  evt_ctrl_reg #(.DATA_W(DATA_W)) u_cr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_cr_i),
    .wdata_i     (wdata_i),
    .cr_o        (cr_o),
    .stop_fall_o (stop_fall)
  );

  assign byte_next = set_v[F_BYTE] | (flag_q[F_BYTE] & ~clr_v[F_BYTE]);

  // nack context lives while the byte flag it came with is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nack_q <= 1'b0;
      mute_q <= 1'b0;
    end else begin
      nack_q <= evt_nack_i | (nack_q & byte_next);
      if (stop_fall & nack_q & flag_q[F_BYTE]) mute_q <= 1'b1;
      else if (evt_stop_i)                     mute_q <= 1'b0;
    end
  end

  assign evf_o = |flag_q;
  assign irq_o = evf_o & cr_o[CR_IE];

  always_comb begin
    sr1_o = '0;
    sr1_o[NFLAG_SR1-1:0] = flag_q[NFLAG_SR1-1:0];
    sr1_o[EVF_BIT] = evf_o;
    sr2_o = '0;
    sr2_o[0] = flag_q[F_NACK];
    sr2_o[1] = flag_q[F_STOP];
  end

  AST_SLV_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sr1_i && !evt_slv_hit_i) |=> !sr1_o[F_SLV]); // R3
  AST_STOP_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sr2_i && !evt_stop_i) |=> !sr2_o[1]); // R8
  AST_STOP_MUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mute_q && evt_stop_i && !flag_q[F_STOP]) |=> !sr2_o[1]); // R10
  AST_BYTE_RX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[F_BYTE] && !tx_mode_i && !armed && rd_dr_i) |=> sr1_o[F_BYTE]); // R4
  AST_NACK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sr1_i && !evt_nack_i) |=> !sr2_o[0]); // R9
endmodule

// File: tb/i2c_evt_flags_test.sv
`timescale 1ns/1ps
module i2c_evt_flags_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tx_mode = 1'b0;
  logic [6:0] ev = '0;
  logic rd_sr1 = 0, rd_sr2 = 0, rd_dr = 0, wr_dr = 0, wr_cr = 0;
  logic [7:0] wdata = '0;
  logic [7:0] sr1, sr2, cr;
  logic evf, irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model state
  logic [6:0] m_f = '0;
  logic m_arm = 0, m_nack = 0, m_mute = 0;
  logic [7:0] m_cr = '0;

  always #2 clk = ~clk;

  i2c_evt_flags uut (
    .clk_i(clk), .rst_ni(rst_ni), .tx_mode_i(tx_mode),
    .evt_start_i(ev[0]), .evt_slv_hit_i(ev[1]), .evt_byte_done_i(ev[2]),
    .evt_hdr_sent_i(ev[3]), .evt_mst_ack_i(ev[4]), .evt_nack_i(ev[5]),
    .evt_stop_i(ev[6]),
    .rd_sr1_i(rd_sr1), .rd_sr2_i(rd_sr2), .rd_dr_i(rd_dr), .wr_dr_i(wr_dr),
    .wr_cr_i(wr_cr), .wdata_i(wdata),
    .sr1_o(sr1), .sr2_o(sr2), .cr_o(cr), .evf_o(evf), .irq_o(irq)
  );

  function automatic logic [7:0] exp_sr1();
    return {|m_f, 2'b00, m_f[4:0]};
  endfunction
  function automatic logic [7:0] exp_sr2();
    return {6'b0, m_f[6], m_f[5]};
  endfunction
  function automatic logic exp_irq();
    return (|m_f) & m_cr[0];
  endfunction

  task automatic model_update();
    logic [6:0] n;
    logic acc_o, sfall, rel, arm_n;
    acc_o = rd_sr2 | rd_dr | wr_dr | wr_cr;
    arm_n = rd_sr1 ? (|m_f) : (acc_o ? 1'b0 : m_arm);
    sfall = wr_cr & m_cr[1] & ~wdata[1];
    rel   = m_nack & (wr_dr | sfall);
    n[0] = ev[0] | (m_f[0] & ~(m_arm & wr_dr));
    n[1] = ev[1] | (m_f[1] & ~rd_sr1);
    n[2] = ev[2] | (m_f[2] & ~(m_arm & (tx_mode ? wr_dr : rd_dr)) & ~rel);
    n[3] = ev[3] | (m_f[3] & ~(m_arm & wr_dr));
    n[4] = ev[4] | (m_f[4] & ~(m_arm & wr_cr));
    n[5] = ev[5] | (m_f[5] & ~rd_sr1);
    n[6] = (ev[6] & ~m_mute) | (m_f[6] & ~rd_sr2);
    if (sfall & m_nack & m_f[2]) m_mute = 1'b1;
    else if (ev[6])              m_mute = 1'b0;
    m_nack = ev[5] | (m_nack & n[2]);
    if (wr_cr) m_cr = wdata;
    m_arm = arm_n;
    m_f = n;
  endtask

  // k: 0 none, 1 sr1 rd, 2 sr2 rd, 3 dr rd, 4 dr wr, 5 cr wr
  task automatic cyc(input logic [6:0] e, input int k, input logic [7:0] d);
    ev = e; rd_sr1 = (k == 1); rd_sr2 = (k == 2); rd_dr = (k == 3);
    wr_dr = (k == 4); wr_cr = (k == 5); wdata = d;
    @(posedge clk);
    model_update();
    #1;
    ev = '0; rd_sr1 = 0; rd_sr2 = 0; rd_dr = 0; wr_dr = 0; wr_cr = 0;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    #9 rst_ni = 1'b1;
    #1;
    chk("R1 sr1", sr1, 8'h00); chk("R1 sr2", sr2, 8'h00);
    chk("R1 cr", cr, 8'h00);   chk("R1 irq", {7'b0, irq}, 8'h00);

    // R3
    cyc(7'h02, 0, 0); chk("R3 set", sr1, 8'h82);
    cyc(0, 1, 0);     chk("R3 clear", sr1, 8'h00);
    // R2
    cyc(7'h02, 0, 0); chk("R2 masked irq", {7'b0, irq}, 8'h00);
    cyc(0, 5, 8'h01); chk("R2 irq on", {7'b0, irq}, 8'h01);
    chk("R2 evf", {7'b0, evf}, 8'h01);
    cyc(0, 1, 0);     chk("R2 irq off", {7'b0, irq}, 8'h00);
    // R4
    tx_mode = 0;
    cyc(0, 2, 0); cyc(7'h04, 0, 0); cyc(0, 3, 0);
    chk("R4 dr read alone", sr1, 8'h84);
    cyc(0, 1, 0); cyc(0, 3, 0); chk("R4 clear", sr1, 8'h00);
    // R5
    tx_mode = 1;
    cyc(0, 2, 0); cyc(7'h04, 0, 0); cyc(0, 1, 0); cyc(0, 3, 0);
    chk("R5 wrong access", sr1, 8'h84);
    cyc(0, 1, 0); cyc(0, 4, 0); chk("R5 clear", sr1, 8'h00);
    // R6
    cyc(0, 2, 0); cyc(7'h09, 0, 0); chk("R6 set", sr1, 8'h89);
    cyc(0, 1, 0); cyc(0, 4, 0);     chk("R6 clear", sr1, 8'h00);
    // R7
    cyc(0, 2, 0); cyc(7'h10, 0, 0); cyc(0, 1, 0); cyc(0, 4, 0);
    chk("R7 dr write keeps", sr1, 8'h90);
    cyc(0, 1, 0); cyc(0, 5, 8'h01); chk("R7 clear", sr1, 8'h00);
    // R8
    cyc(7'h40, 0, 0); chk("R8 set", sr2, 8'h02);
    chk("R8 irq", {7'b0, irq}, 8'h01);
    cyc(0, 1, 0); chk("R8 sr1 read keeps", sr2, 8'h02);
    cyc(0, 2, 0); chk("R8 clear", sr2, 8'h00);
    // R11
    tx_mode = 0;
    cyc(0, 2, 0); cyc(7'h04, 0, 0); cyc(0, 1, 0); cyc(0, 2, 0); cyc(0, 3, 0);
    chk("R11 disarmed", sr1, 8'h84);
    cyc(0, 1, 0); cyc(0, 3, 0); chk("R11 cleanup", sr1, 8'h00);
    cyc(0, 1, 0); cyc(7'h01, 0, 0); cyc(0, 4, 0);
    chk("R11 unarmed read", sr1, 8'h81);
    cyc(0, 1, 0); cyc(0, 4, 0); chk("R11 cleanup2", sr1, 8'h00);
    // R9 stop-bit toggle
    cyc(0, 2, 0); cyc(7'h24, 0, 0); chk("R9 nack set", sr2, 8'h01);
    cyc(0, 1, 0); chk("R9 nack clear", sr2, 8'h00);
    chk("R9 byte held", sr1, 8'h84);
    cyc(0, 5, 8'h03); chk("R9 stop set keeps", sr1, 8'h84);
    cyc(0, 5, 8'h01); chk("R9 toggle release", sr1, 8'h00);
    // R10
    cyc(7'h40, 0, 0); chk("R10 muted stop", sr2, 8'h00);
    cyc(7'h40, 0, 0); chk("R10 next stop", sr2, 8'h02);
    cyc(0, 2, 0);
    // R9 data write path
    cyc(7'h24, 0, 0); cyc(0, 4, 0); chk("R9 dr write release", sr1, 8'h80);
    cyc(0, 1, 0); chk("R9 all clear", sr1, 8'h00);
    // R12
    cyc(0, 2, 0); cyc(7'h01, 0, 0); cyc(0, 1, 0); cyc(7'h01, 4, 0);
    chk("R12 start wins", sr1, 8'h81);
    cyc(0, 1, 0); cyc(0, 4, 0);
    cyc(7'h02, 1, 0); chk("R12 hit wins", sr1, 8'h82);
    cyc(0, 1, 0); chk("R12 cleanup", sr1, 8'h00);

    // R13 random traffic
    for (int i = 0; i < 800; i++) begin
      logic [6:0] e;
      for (int b = 0; b < 7; b++) e[b] = (($urandom % 8) == 0);
      if (($urandom % 16) == 0) tx_mode = ~tx_mode;
      cyc(e, int'($urandom % 6), 8'($urandom % 4));
      chk("R13 sr1", sr1, exp_sr1());
      chk("R13 sr2", sr2, exp_sr2());
      chk("R13 irq", {7'b0, irq}, {7'b0, exp_irq()});
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule